// File: doc/BRIEF.md
# Byte-Wide Static Memory Controller with Supply-Fault Write Lockout

This controller sits between a synchronous request port and an asynchronous byte-wide static memory with 32,768 locations. On the memory side it drives a 15-bit address, active-low chip-select, read-strobe and write-strobe pins, and a split data bus: an output byte, a drive-enable and an input byte. Those three meet at a tristate pad outside the block. On the system side the requester raises `req_valid` with the operation, address and data. It holds them until a one-cycle `req_ack` comes back, together with the read byte and an error flag.

The memory's analog timing limits are set as clock-cycle counts through parameters. These cover the read access delay, the data set-up time inside the write window, the data hold time after the window and the idle recovery gap between accesses. The read access count must cover the slowest of the address, chip-select and read-strobe access delays.

A `pwr_fail` input locks out writes. A write requested while it is high is answered at once with the error flag, and no strobe moves. If `pwr_fail` rises while the write strobe is low, the strobe is raised on the next clock. The cycle then closes normally with the error flag set. Reads still work while `pwr_fail` is high.

Top module: `sram_pfw_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_t` is 0 and `req_ack` is 0.
- R2: A read holds `mem_we_n` at 1 and `mem_ce_n` at 0. It holds `mem_oe_n` low for exactly T_ACC cycles and captures `mem_dq_i` on the clock edge that ends the last of those cycles. It then returns that byte on `rsp_rdata` with `rsp_err` at 0.
- R3: A write holds `mem_oe_n` at 1 throughout. It holds `mem_we_n` low for exactly T_SETUP cycles, always inside a low `mem_ce_n`. The byte written is `req_wdata`, and a later read of the same address returns it.
- R4: `mem_addr` does not change while `mem_ce_n` is low, and `mem_dq_o` does not change while `mem_dq_t` stays 1. After the write strobe rises, data stays driven for T_HOLD cycles with `mem_ce_n` and `mem_we_n` both high.
- R5: Between the end of one access and the next falling edge of `mem_ce_n`, `mem_ce_n` stays high for at least T_RECOV cycles.
- R6: `mem_dq_t` is 0 in every cycle in which `mem_oe_n` is 0 and in the cycle before it.
- R7: A write requested while `pwr_fail` is 1 is answered on the next cycle with `req_ack` and `rsp_err` both 1. `mem_ce_n` and `mem_we_n` stay high and the stored byte is left unchanged.
- R8: If `pwr_fail` is 1 on a clock edge while `mem_we_n` is 0, then `mem_we_n` is 1 after that edge. The write completes with `rsp_err` 1.
- R9: Reads are not affected by `pwr_fail`: they return the stored byte with `rsp_err` 0. The next accepted operation clears a previous error flag.
- R10: `req_ack` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| rsp_err | output | 1 | Write refused or cut short by supply fault |
| pwr_fail | input | 1 | Supply out of tolerance; blocks writes |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_t | output | 1 | 1 = controller drives the data pad |
| mem_dq_i | input | 8 | Data from the memory pad |

## Verification
The assertions assume that the requester keeps `req_valid` and its fields steady until `req_ack`, and lowers `req_valid` in the acknowledge cycle. The bench tasks raise a request on a falling edge and drop it on the falling edge where they first see the acknowledge, so they never break that rule. The memory model returns the inverted byte until the read strobe has been low for T_ACC cycles, so a capture made early shows up as wrong data. `pwr_fail` is changed only on falling edges, and mid-write only once the write strobe is seen low, so a cut always lands inside a real write window.

// File: rtl/sram_pfw_pkg.sv
package sram_pfw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_SET = 3'd1,
    ST_RD_ACC = 3'd2,
    ST_WR_SET = 3'd3,
    ST_WR_PLS = 3'd4,
    ST_WR_HLD = 3'd5,
    ST_RECOV  = 3'd6
  } seq_st_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_t;
  } pin_s;

  // Pin levels for each sequencer state
  function automatic pin_s pins_of(seq_st_e s);
    pin_s p;
    p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_t: 1'b0};
    case (s)
      ST_RD_SET: p.ce_n = 1'b0;
      ST_RD_ACC: begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      ST_WR_SET: begin p.ce_n = 1'b0; p.dq_t = 1'b1; end
      ST_WR_PLS: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.dq_t = 1'b1; end
      ST_WR_HLD: p.dq_t = 1'b1;
      default:   p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_t: 1'b0};
    endcase
    return p;
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_pfw_pkg::*;
#(
  parameter int T_ACC   = 3,
  parameter int T_SETUP = 2,
  parameter int T_HOLD  = 1,
  parameter int T_RECOV = 2,
  parameter int CNT_W   = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    req_write,
  input  logic    pwr_fail,
  output seq_st_e st_d,
  output logic    accept,
  output logic    cap_rd,
  output logic    ack_q,
  output logic    err_q
);
  localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(T_ACC - 1);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(T_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(T_HOLD - 1);
  localparam logic [CNT_W-1:0] LD_RECOV = CNT_W'(T_RECOV - 1);

  seq_st_e          st_q;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             tmr_zero;
  logic             ack_d;
  logic             err_d;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    ack_d  = 1'b0;
    err_d  = err_q;
    accept = 1'b0;
    cap_rd = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write && pwr_fail) begin
            st_d   = ST_RECOV;
            ld     = 1'b1;
            ld_val = LD_RECOV;
            ack_d  = 1'b1;
            err_d  = 1'b1;
          end else begin
            err_d = 1'b0;
            st_d  = req_write ? ST_WR_SET : ST_RD_SET;
          end
        end
      end
      ST_RD_SET: begin
        st_d   = ST_RD_ACC;
        ld     = 1'b1;
        ld_val = LD_ACC;
      end
      ST_RD_ACC: begin
        if (tmr_zero) begin
          st_d   = ST_RECOV;
          ld     = 1'b1;
          ld_val = LD_RECOV;
          ack_d  = 1'b1;
          cap_rd = 1'b1;
        end
      end
      ST_WR_SET: begin
        ld = 1'b1;
        if (pwr_fail) begin
          st_d   = ST_WR_HLD;
          ld_val = LD_HOLD;
          err_d  = 1'b1;
        end else begin
          st_d   = ST_WR_PLS;
          ld_val = LD_SETUP;
        end
      end
      ST_WR_PLS: begin
        if (pwr_fail || tmr_zero) begin
          st_d   = ST_WR_HLD;
          ld     = 1'b1;
          ld_val = LD_HOLD;
          if (pwr_fail) err_d = 1'b1;
        end
      end
      ST_WR_HLD: begin
        if (tmr_zero) begin
          st_d   = ST_RECOV;
          ld     = 1'b1;
          ld_val = LD_RECOV;
          ack_d  = 1'b1;
        end
      end
      ST_RECOV: begin
        if (tmr_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_pfw_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_st_e           st_d,
  input  logic              accept,
  input  logic              cap_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dq_t,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rsp_rdata
);
  pin_s pin_d;

  assign pin_d = pins_of(st_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_dq_t <= 1'b0;
    end else begin
      mem_ce_n <= pin_d.ce_n;
      mem_oe_n <= pin_d.oe_n;
      mem_we_n <= pin_d.we_n;
      mem_dq_t <= pin_d.dq_t;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      if (cap_rd) rsp_rdata <= mem_dq_i;
    end
  end
endmodule

// File: rtl/sram_pfw_ctrl.sv
module sram_pfw_ctrl
  import sram_pfw_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int T_ACC   = 3,
  parameter int T_SETUP = 2,
  parameter int T_HOLD  = 1,
  parameter int T_RECOV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic              pwr_fail,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_t,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int T_MAX = max4(T_ACC, T_SETUP, T_HOLD, T_RECOV);
  localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  seq_st_e st_d;
  logic    accept;
  logic    cap_rd;

  sram_seq_fsm #(
    .T_ACC   (T_ACC),
    .T_SETUP (T_SETUP),
    .T_HOLD  (T_HOLD),
    .T_RECOV (T_RECOV),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .pwr_fail  (pwr_fail),
    .st_d      (st_d),
    .accept    (accept),
    .cap_rd    (cap_rd),
    .ack_q     (req_ack),
    .err_q     (rsp_err)
  );

  sram_pin_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .st_d      (st_d),
    .accept    (accept),
    .cap_rd    (cap_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_t  (mem_dq_t),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/sram_pfw_ctrl_chk.sv
module sram_pfw_ctrl_chk #(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int T_RECOV = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_fail,
  input logic              req_ack,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_t,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o
);
  localparam int GAP_W = $clog2(T_RECOV + 2);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(T_RECOV);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                   gap_q <= GAP_SAT;
    else if (!mem_ce_n)        gap_q <= '0;
    else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
  end

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> mem_oe_n); // R3
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> !mem_ce_n); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst) (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R4
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst) (mem_dq_t && $past(mem_dq_t)) |-> $stable(mem_dq_o)); // R4
  AST_RECOV_GAP: assert property (@(posedge clk) disable iff (rst) $fell(mem_ce_n) |-> (gap_q >= GAP_SAT)); // R5
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst) !mem_oe_n |-> (!mem_dq_t && !$past(mem_dq_t))); // R6
  AST_PF_CUTS_WE: assert property (@(posedge clk) disable iff (rst) (pwr_fail && !mem_we_n) |=> mem_we_n); // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst) req_ack |=> !req_ack); // R10
endmodule

bind sram_pfw_ctrl sram_pfw_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .T_RECOV (T_RECOV)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_fail (pwr_fail),
  .req_ack  (req_ack),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_dq_t (mem_dq_t),
  .mem_addr (mem_addr),
  .mem_dq_o (mem_dq_o)
);

// File: tb/sram_pfw_ctrl_tb.sv
module sram_pfw_ctrl_tb;
  localparam int AW = 15, DW = 8;
  localparam int T_ACC = 3, T_SETUP = 2, T_HOLD = 1, T_RECOV = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, pwr_fail = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ack, rsp_err, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_t;
  logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sram_pfw_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_ACC(T_ACC), .T_SETUP(T_SETUP),
                  .T_HOLD(T_HOLD), .T_RECOV(T_RECOV)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pwr_fail(pwr_fail),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_t(mem_dq_t),
    .mem_dq_i(mem_dq_i));

  // Power-up contents, computed from the address
  function automatic logic [7:0] init_byte(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  // ---------------- memory model and pin monitors ----------------
  logic [7:0] mdl_ovl [int];
  logic [7:0] exp_ovl [int];
  logic [7:0] mdl_byte = '0;
  int oe_cnt = 0;
  int cnt_we_low = 0, cnt_ce_low = 0, cnt_oe_wr = 0, cnt_hold = 0;
  int viol_addr = 0, viol_bus = 0, viol_ack = 0, viol_cont = 0;
  int gap_run = 0, min_gap = 1000;
  bit seen_acc = 0, prev_dqt = 0, prev_ack = 0, prev_act = 0;
  logic [AW-1:0] prev_addr = '0;

  always_comb begin
    if (mem_dq_t) mem_dq_i = mem_dq_o;
    else if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_i = (oe_cnt >= T_ACC) ? mdl_byte : ~mdl_byte;
    else mem_dq_i = 8'h00;
  end

  always @(negedge clk) begin
    if (!rst) begin
      int a;
      a = int'(mem_addr);
      if (!mem_ce_n && !mem_oe_n) oe_cnt = oe_cnt + 1; else oe_cnt = 0;
      if (!mem_ce_n) mdl_byte = mdl_ovl.exists(a) ? mdl_ovl[a] : init_byte(a);
      if (!mem_ce_n && !mem_we_n) begin
        mdl_ovl[a] = mem_dq_o;
        cnt_we_low++;
      end
      if (!mem_ce_n) cnt_ce_low++;
      if (!mem_oe_n && (mem_dq_t || !mem_we_n)) cnt_oe_wr++;
      if (mem_dq_t && mem_ce_n && mem_we_n) cnt_hold++;
      if (!mem_oe_n && (mem_dq_t || prev_dqt)) viol_bus++;
      if (!mem_oe_n && !mem_ce_n && mem_dq_t) viol_cont++;
      if (req_ack && prev_ack) viol_ack++;
      if ((!mem_ce_n || mem_dq_t) && prev_act && mem_addr != prev_addr) viol_addr++;
      if (!mem_ce_n) begin
        if (seen_acc && gap_run > 0 && gap_run < min_gap) min_gap = gap_run;
        seen_acc = 1;
        gap_run = 0;
      end else gap_run++;
      prev_dqt = mem_dq_t;
      prev_ack = req_ack;
      prev_act = !mem_ce_n || mem_dq_t;
      prev_addr = mem_addr;
    end
  end

  // ---------------- reporting ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_err = n_err + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  // One request; pf_mid raises pwr_fail once the write strobe is seen low
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit pf_mid, output logic [DW-1:0] rd, output bit er);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (pf_mid && !mem_we_n) pwr_fail = 1'b1;
    end while (!req_ack && n < 200);
    req_valid = 1'b0;
    rd = rsp_rdata;
    er = rsp_err;
    if (n >= 200) chk(1'b0, "R10 ack missing", n, 0);
  endtask

  function automatic logic [7:0] exp_of(int a);
    return exp_ovl.exists(a) ? exp_ovl[a] : init_byte(a);
  endfunction

  initial begin
    logic [DW-1:0] rd;
    bit er;
    int we0, ce0, hd0, bad;

    // R1: reset levels
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_t && !req_ack, "R1 bus/ack in reset", {mem_dq_t, req_ack}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_t && !req_ack, "R1 after reset",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_t, req_ack}, 5'b11100);

    // R2: read sweep over every address bit pattern family
    bad = 0;
    for (int i = 0; i < 2048; i++) begin
      int a;
      a = (i << 4) | (i & 15);
      do_op(1'b0, AW'(a), 8'h00, 1'b0, rd, er);
      chk(rd == init_byte(a) && !er, "R2 read data", rd, init_byte(a));
    end

    // R2: strobe low time of one read
    ce0 = cnt_ce_low;
    do_op(1'b0, 15'h1234, 8'h00, 1'b0, rd, er);
    chk(cnt_ce_low - ce0 == T_ACC + 1, "R2 chip select cycles", cnt_ce_low - ce0, T_ACC + 1);

    // R3/R4: writes then readback
    for (int i = 0; i < 64; i++) begin
      int a;
      logic [7:0] d;
      a = (i * 509) % 32768;
      d = 8'(i * 37 + 3);
      we0 = cnt_we_low; hd0 = cnt_hold;
      do_op(1'b1, AW'(a), d, 1'b0, rd, er);
      exp_ovl[a] = d;
      chk(cnt_we_low - we0 == T_SETUP, "R3 write strobe width", cnt_we_low - we0, T_SETUP);
      chk(cnt_hold - hd0 == T_HOLD, "R4 data hold cycles", cnt_hold - hd0, T_HOLD);
      chk(!er, "R3 write no error", er, 0);
    end
    for (int i = 0; i < 64; i++) begin
      int a;
      a = (i * 509) % 32768;
      do_op(1'b0, AW'(a), 8'h00, 1'b0, rd, er);
      chk(rd == exp_of(a), "R3 readback", rd, exp_of(a));
    end

    // R7: write refused while supply is out of tolerance
    @(negedge clk); pwr_fail = 1'b1;
    ce0 = cnt_ce_low; we0 = cnt_we_low;
    do_op(1'b1, 15'd100, 8'hEE, 1'b0, rd, er);
    chk(er, "R7 refused write flags error", er, 1);
    chk(cnt_ce_low == ce0 && cnt_we_low == we0, "R7 no strobe activity", cnt_ce_low - ce0, 0);
    // R9: read under power fail still works, error cleared
    do_op(1'b0, 15'd100, 8'h00, 1'b0, rd, er);
    chk(rd == exp_of(100), "R7 stored byte kept", rd, exp_of(100));
    chk(!er, "R9 read under pwr_fail no error", er, 0);
    @(negedge clk); pwr_fail = 1'b0;

    // R8: supply fault in the middle of the write window
    we0 = cnt_we_low;
    do_op(1'b1, 15'd200, 8'h11, 1'b1, rd, er);
    chk(er, "R8 cut write flags error", er, 1);
    chk(cnt_we_low - we0 == 1, "R8 strobe cut after one cycle", cnt_we_low - we0, 1);
    @(negedge clk); pwr_fail = 1'b0;
    do_op(1'b1, 15'd200, 8'h22, 1'b0, rd, er);
    exp_ovl[200] = 8'h22;
    chk(!er, "R9 next write clears error", er, 0);
    do_op(1'b0, 15'd200, 8'h00, 1'b0, rd, er);
    chk(rd == 8'h22, "R8 rewrite after fault", rd, 8'h22);

    // Pin-level rules gathered over the whole run
    chk(cnt_oe_wr == 0, "R3 read strobe high during writes", cnt_oe_wr, 0);
    chk(viol_addr == 0, "R4 address stable in cycle", viol_addr, 0);
    chk(min_gap >= T_RECOV + 1, "R5 recovery gap", min_gap, T_RECOV + 1);
    chk(viol_bus == 0 && viol_cont == 0, "R6 bus released around read strobe", viol_bus + viol_cont, 0);
    chk(viol_ack == 0, "R10 ack single cycle", viol_ack, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule